// File: doc/BRIEF.md
# Switching Timebase with Shared Sync Line

This block is the digital clock source of a fixed-frequency PWM converter. A period counter running on the system clock marks the start of every switching cycle with a one-cycle strobe. Halfway through each cycle it emits a short pulse on a sync output. A setting of zero selects the default rate. A non-zero setting can shorten the period, which raises the switching frequency up to a ceiling. The sampled setting applies only from the next cycle start.

The same pin pair lets the block follow an external timing source. Every sync input pulse that passes a width filter starts a new switching cycle at once and truncates the running one. When two blocks share one open line, the faster block keeps driving it and the slower one stops driving and follows. Each follower cycle starts half of the leader's period after the leader's cycle start.

Top module: `swclk_sync`

## Requirements
- R1: Reset holds cyc_start and sync_out low and sync_oe high (leader role). Counting begins at the first clock edge without reset. The first cyc_start appears exactly one period after reset is released.
- R2: The period in system clocks is DEF_PERIOD when period_cfg is 0 or above DEF_PERIOD, MIN_PERIOD when it is below MIN_PERIOD, and period_cfg otherwise. In free running, cyc_start is a one-cycle strobe repeating at that period.
- R3: period_cfg is sampled only at a cycle start (and during reset). Changing it mid-cycle leaves the length of the cycle in progress unchanged.
- R4: sync_out is high for OUT_W cycles, rising floor(P/2) - MIN_W cycles after cyc_start. This lead equals the follower's filter delay, so the follower starts exactly floor(P/2) cycles after the leader.
- R5: A sync_in pulse high for fewer than MIN_W consecutive cycles is ignored. A pulse high for MIN_W or more cycles is accepted exactly once, however long it lasts.
- R6: For an accepted pulse, cyc_start rises MIN_W cycles after sync_in rose and the period counter restarts from zero, truncating the cycle in progress. Any sync_out pulse in progress is dropped.
- R7: An accepted pulse makes the block a follower: sync_oe falls in the same cycle as the resulting cyc_start. A full period that ends with no accepted pulse makes it leader again: sync_oe is high from that cyc_start.
- R8: While the block itself drives the line (sync_oe and sync_out both high), a high sync_in is not counted. The block's own pulse never restarts its own cycle.
- R9: On a shared wired-OR line, the unit with the shorter period stays leader with its period unchanged. The other unit releases the line and starts each cycle floor(Pleader/2) cycles after the leader's cycle start.
- R10: If a pulse is accepted in the same cycle that the period expires, a single cyc_start results and the block becomes a follower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| period_cfg | input | PER_W | Requested period in system clocks; 0 selects the default |
| sync_in | input | 1 | Sensed level of the sync line, synchronous to clk |
| sync_out | output | 1 | Sync pulse, placed near mid-cycle |
| sync_oe | output | 1 | Drive enable for sync_out; high while leader |
| cyc_start | output | 1 | One-cycle strobe at each switching cycle start |

## Verification
Two events can coincide: the accepted edge from the input filter and the natural expiry of the period counter. The bench provokes this by raising an external pulse exactly MIN_W cycles before a free-running period would end. It then requires one strobe at that cycle, not two, and requires the drive enable to drop. A second collision is the block's own pulse appearing on its sensed line. The shared-line pair exercises this: the leader's period must stay exact while its own pulses return on sync_in.

// File: rtl/swclk_pkg.sv
package swclk_pkg;

    typedef enum logic {
        ROLE_FOLLOW = 1'b0,
        ROLE_LEAD   = 1'b1
    } role_e;

    typedef struct packed {
        logic accept;
        logic expire;
    } cyc_evt_t;

    function automatic int eff_period(input int cfg, input int dflt, input int lo);
        if (cfg == 0 || cfg > dflt) return dflt;
        if (cfg < lo) return lo;
        return cfg;
    endfunction

endpackage

// File: rtl/swclk_in_filter.sv
module swclk_in_filter #(
    parameter int MIN_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    input  logic self_drive,
    output logic accept
);
    localparam int HW = $clog2(MIN_W + 1);

    logic [HW-1:0] hi_cnt;
    logic          seen;

    assign seen   = line_in & ~self_drive;
    assign accept = seen && (hi_cnt == HW'(MIN_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
        end else if (!seen) begin
            hi_cnt <= '0;
        end else if (hi_cnt != HW'(MIN_W)) begin
            hi_cnt <= hi_cnt + HW'(1);
        end
    end

    AST_SINGLE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept); // R5

    generate
        if (MIN_W >= 2) begin : g_hist
            AST_ACC_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (rst)
                accept |-> $past(seen)); // R5
        end
    endgenerate

endmodule

// File: rtl/swclk_period_ctr.sv
module swclk_period_ctr
    import swclk_pkg::*;
#(
    parameter int PER_W      = 10,
    parameter int DEF_PERIOD = 200,
    parameter int MIN_PERIOD = 50
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] period_cfg,
    input  logic             accept,
    output logic [PER_W-1:0] cnt,
    output logic [PER_W-1:0] per_q,
    output logic             cyc_start,
    output role_e            role
);
    logic [PER_W-1:0] per_next;
    cyc_evt_t         evt;

    assign per_next   = PER_W'(eff_period(int'(period_cfg), DEF_PERIOD, MIN_PERIOD));
    assign evt.accept = accept;
    assign evt.expire = (cnt == per_q - PER_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            per_q     <= per_next;
            cyc_start <= 1'b0;
            role      <= ROLE_LEAD;
        end else if (evt.accept) begin
            cnt       <= '0;
            per_q     <= per_next;
            cyc_start <= 1'b1;
            role      <= ROLE_FOLLOW;
        end else if (evt.expire) begin
            cnt       <= '0;
            per_q     <= per_next;
            cyc_start <= 1'b1;
            role      <= ROLE_LEAD;
        end else begin
            cnt       <= cnt + PER_W'(1);
            cyc_start <= 1'b0;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt < per_q); // R2

    AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (rst)
        !$stable(per_q) |-> (cyc_start || $past(rst))); // R3

    AST_FOLLOW_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> (role == ROLE_FOLLOW && cyc_start && cnt == '0)); // R7, R10

    AST_LEAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        (evt.expire && !accept) |=> (role == ROLE_LEAD && cyc_start)); // R7

endmodule

// File: rtl/swclk_pulse_gen.sv
module swclk_pulse_gen #(
    parameter int PER_W = 10,
    parameter int MIN_W = 4,
    parameter int OUT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] cnt,
    input  logic [PER_W-1:0] per_q,
    input  logic             accept,
    output logic             pulse
);
    localparam int OW = $clog2(OUT_W + 1);

    logic [OW-1:0]    left;
    logic [PER_W-1:0] lead;
    logic             trig;

    assign lead  = (per_q >> 1) - PER_W'(MIN_W);
    assign trig  = (cnt == lead - PER_W'(1)) && !accept;
    assign pulse = (left != '0);

    always_ff @(posedge clk) begin
        if (rst || accept) begin
            left <= '0;
        end else if (trig) begin
            left <= OW'(OUT_W);
        end else if (left != '0) begin
            left <= left - OW'(1);
        end
    end

    AST_PULSE_AT_LEAD: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse) |-> (cnt == lead)); // R4

    AST_PULSE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        accept |=> !pulse); // R6

endmodule

// File: rtl/swclk_sync.sv
module swclk_sync
    import swclk_pkg::*;
#(
    parameter int PER_W      = 10,
    parameter int DEF_PERIOD = 200,
    parameter int MIN_PERIOD = 50,
    parameter int MIN_W      = 4,
    parameter int OUT_W      = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] period_cfg,
    input  logic             sync_in,
    output logic             sync_out,
    output logic             sync_oe,
    output logic             cyc_start
);
    logic [PER_W-1:0] cnt;
    logic [PER_W-1:0] per_q;
    logic             accept;
    logic             self_drive;
    role_e            role;

    assign sync_oe    = (role == ROLE_LEAD);
    assign self_drive = sync_oe & sync_out;

    swclk_in_filter #(.MIN_W(MIN_W)) u_filter (
        .clk        (clk),
        .rst        (rst),
        .line_in    (sync_in),
        .self_drive (self_drive),
        .accept     (accept)
    );

    swclk_period_ctr #(
        .PER_W      (PER_W),
        .DEF_PERIOD (DEF_PERIOD),
        .MIN_PERIOD (MIN_PERIOD)
    ) u_ctr (
        .clk        (clk),
        .rst        (rst),
        .period_cfg (period_cfg),
        .accept     (accept),
        .cnt        (cnt),
        .per_q      (per_q),
        .cyc_start  (cyc_start),
        .role       (role)
    );

    swclk_pulse_gen #(
        .PER_W (PER_W),
        .MIN_W (MIN_W),
        .OUT_W (OUT_W)
    ) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .cnt    (cnt),
        .per_q  (per_q),
        .accept (accept),
        .pulse  (sync_out)
    );

    AST_OWN_PULSE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        self_drive |-> !accept); // R8

endmodule

// File: tb/swclk_sync_bench.sv
module swclk_sync_bench;
    localparam int PER_W = 10;
    localparam int DEF_P = 200;
    localparam int MIN_P = 50;
    localparam int MIN_W = 4;
    localparam int OUT_W = 6;
    localparam int PA    = 60;
    localparam int PB    = 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_err = 0;

    logic [PER_W-1:0] cfg_c = '0;
    logic             ext   = 1'b0;
    logic             so_c, oe_c, st_c;
    logic             so_a, oe_a, st_a;
    logic             so_b, oe_b, st_b;
    logic             line_ab;

    assign line_ab = (oe_a & so_a) | (oe_b & so_b);

    swclk_sync u_swclk_sync (
        .clk(clk), .rst(rst), .period_cfg(cfg_c), .sync_in(ext),
        .sync_out(so_c), .sync_oe(oe_c), .cyc_start(st_c));

    swclk_sync u_swclk_sync_a (
        .clk(clk), .rst(rst), .period_cfg(PER_W'(PA)), .sync_in(line_ab),
        .sync_out(so_a), .sync_oe(oe_a), .cyc_start(st_a));

    swclk_sync u_swclk_sync_b (
        .clk(clk), .rst(rst), .period_cfg(PER_W'(PB)), .sync_in(line_ab),
        .sync_out(so_b), .sync_oe(oe_b), .cyc_start(st_b));

    int last_c = 0;
    int n_c    = 0;
    always @(negedge clk) begin
        if (!rst && st_c) begin
            last_c <= cyc;
            n_c    <= n_c + 1;
        end
    end

    task automatic chk_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_period(input int cfg);
        if (cfg == 0 || cfg > DEF_P) return DEF_P;
        if (cfg < MIN_P) return MIN_P;
        return cfg;
    endfunction

    task automatic wait_c_start(output int t);
        do @(negedge clk); while (!st_c);
        t = cyc;
    endtask

    task automatic measure_pulse_c(input int t0, output int off, output int w);
        do @(negedge clk); while (!so_c);
        off = cyc - t0;
        w = 0;
        while (so_c) begin
            w++;
            @(negedge clk);
        end
    endtask

    task automatic wait_until(input int target);
        while (cyc != target) @(negedge clk);
    endtask

    int r0 = 0;

    task automatic run_c();
        int t, t2, tprev, prev_p, p, off, w, prev, n0, width;
        int cfgs[9] = '{0, 30, 50, 51, 77, 128, 200, 201, 1023};
        wait_c_start(t);
        chk_eq("R1 first start after reset", t - r0, DEF_P);
        tprev  = t;
        prev_p = DEF_P;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            cfg_c = PER_W'(cfgs[i]);
            wait_c_start(t);
            chk_eq("R3 cycle in flight keeps old period", t - tprev, prev_p);
            p = exp_period(cfgs[i]);
            measure_pulse_c(t, off, w);
            chk_eq("R4 sync_out lead", off, p / 2 - MIN_W);
            chk_eq("R4 sync_out width", w, OUT_W);
            wait_c_start(t2);
            chk_eq("R2 period", t2 - t, p);
            prev_p = p;
            tprev  = t2;
        end
        // collision of accept and expiry (R10)
        @(negedge clk);
        cfg_c = PER_W'(100);
        wait_c_start(t);
        wait_until(t + 96);
        n0  = n_c;
        ext = 1'b1;
        repeat (MIN_W) @(negedge clk);
        ext = 1'b0;
        repeat (3) @(negedge clk);
        chk_eq("R10 start at collision cycle", last_c, t + 100);
        chk_eq("R10 single start", n_c - n0, 1);
        chk_eq("R10 becomes follower", int'(oe_c), 0);
        prev = t + 100;
        // lock to a faster source
        for (int k = 0; k < 3; k++) begin
            width = (k == 1) ? 20 : MIN_W;
            wait_until(prev + 66);
            n0  = n_c;
            ext = 1'b1;
            repeat (width) @(negedge clk);
            ext = 1'b0;
            repeat (3) @(negedge clk);
            chk_eq("R6 start MIN_W after rise", last_c, prev + 70);
            chk_eq("R5 one accept per pulse", n_c - n0, 1);
            chk_eq("R7 follower releases line", int'(oe_c), 0);
            prev = prev + 70;
        end
        // short pulse rejected, then fallback to leader
        wait_until(prev + 20);
        n0  = n_c;
        ext = 1'b1;
        repeat (MIN_W - 1) @(negedge clk);
        ext = 1'b0;
        wait_until(prev + 102);
        chk_eq("R5 short pulse ignored, own expiry only", n_c - n0, 1);
        chk_eq("R5 start at own expiry", last_c, prev + 100);
        chk_eq("R7 leader again after silent period", int'(oe_c), 1);
    endtask

    task automatic run_ab();
        int ta, tb, ta_prev;
        ta_prev = 0;
        repeat (300) @(negedge clk);
        chk_eq("R9 faster unit leads", int'(oe_a), 1);
        chk_eq("R9 slower unit released line", int'(oe_b), 0);
        for (int k = 0; k < 4; k++) begin
            do @(negedge clk); while (!st_a);
            ta = cyc;
            do @(negedge clk); while (!st_b);
            tb = cyc;
            chk_eq("R9 follower half period behind", tb - ta, PA / 2);
            if (k > 0) chk_eq("R8 leader period unaffected by own pulse", ta - ta_prev, PA);
            ta_prev = ta;
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_eq("R1 reset cyc_start", int'(st_c), 0);
        chk_eq("R1 reset sync_out", int'(so_c), 0);
        chk_eq("R1 reset sync_oe", int'(oe_c), 1);
        rst = 1'b0;
        r0  = cyc;
        fork
            run_c();
            run_ab();
        join
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 0);
        summary();
        $finish;
    end

endmodule